// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbiter

This block arbitrates among eight interrupt request lines and drives a single interrupt line toward a processor. Each request line is captured in a pending register, either on a rising edge or by following the line's level, as chosen per line. A mask register keeps lines out of arbitration. An in-service register records the requests that are being serviced. Priority is circular: a programmable base index names the line with the highest priority, and priority falls off in increasing index order, wrapping around modulo eight.

The interrupt line is raised only when the best unmasked pending request beats every request already in service. The in-service set can leave out masked lines (special mask mode) or the cascade line, index 2, on a master unit (special fully nested mode). On an acknowledge strobe the block reports the winning index. It then records that index as in service, unless automatic end-of-interrupt is selected, and drops an edge-captured request. In automatic end-of-interrupt mode the block can also move the base to the line after the winner. Command decoding and vector formation are left to the surrounding logic, which drives the strobes and mode bits directly.

Top module: `prio_irq_arbiter`

## Requirements
- R1: Asserting `rst_n` low clears the pending, mask, in-service, previous-level and base registers and also the trigger-mode register (all lines edge mode). `int_o` is then low.
- R2: For a line in edge mode (trigger bit 0), the pending bit is set only when the line is high and was low on the previous clock. A line held high does not set it again, and a falling line leaves the pending bit set.
- R3: For a line in level mode (trigger bit 1), the pending bit equals the line value sampled at the previous clock edge, and an acknowledge does not clear it.
- R4: A pending line whose mask bit is 1 takes no part in arbitration and cannot raise `int_o`.
- R5: Line n has priority rank (n − base) mod 8, where rank 0 is highest. `win_idx_o` names the unmasked pending line with the lowest rank. `prio_ld_i` loads the base from `prio_base_i`.
- R6: `int_o` is high only when the best pending rank is strictly lower than the best rank among the counted in-service bits. An empty set has rank 8.
- R7: With `spec_mask_i` high, in-service bits whose mask bit is set are not counted.
- R8: With `nested_i` and `master_i` both high, in-service bit 2 is not counted. With either one low, it is counted.
- R9: An acknowledge while `int_o` is high and `auto_eoi_i` is low sets the winner's in-service bit and clears its pending bit if the line is in edge mode.
- R10: An acknowledge with `auto_eoi_i` high leaves the in-service register unchanged. If `rot_aeoi_i` is also high, the base becomes (winner + 1) mod 8.
- R11: `init_i` clears the pending, mask, in-service, previous-level and base registers but keeps the trigger-mode register.
- R12: Each set bit of `isr_clr_i` clears the matching in-service bit.
- R13: `int_o` and `win_idx_o` are derived combinationally from registered state, so input changes show up one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| init_i | input | 1 | Synchronous re-initialisation that keeps the trigger modes |
| req_i | input | 8 | Raw request lines |
| trig_wr_i | input | 1 | Load strobe for the trigger-mode register |
| trig_i | input | 8 | Trigger modes, 1 = level, 0 = edge |
| mask_wr_i | input | 1 | Load strobe for the mask register |
| mask_i | input | 8 | Mask value, 1 = masked |
| spec_mask_i | input | 1 | Special mask mode |
| nested_i | input | 1 | Special fully nested mode |
| master_i | input | 1 | Unit is the master of a cascade |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate the base on an automatic end-of-interrupt |
| prio_ld_i | input | 1 | Load strobe for the priority base |
| prio_base_i | input | 3 | Index of the new highest-priority line |
| isr_clr_i | input | 8 | In-service clear bits |
| ack_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | Interrupt line |
| win_idx_o | output | 3 | Index of the winning request, meaningful while int_o is high |

## Verification
A vector table tries the arbiter with several base values, using sparse, adjacent, full and empty request patterns. Each pattern is chosen so that a different winner follows from wrap-around than from fixed index order. Directed sequences then nest requests against in-service bits. They tell apart strictly-better from equal rank, counted from uncounted in-service bits under the special mask and nested modes, and edge from level capture through held, falling and acknowledged lines. Re-initialisation and full reset are told apart by a level-mode line that is dropped afterwards: an edge-captured request stays pending, while a level one does not.

// File: rtl/pra_pkg.sv
package pra_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_mode_e;

  typedef struct packed {
    logic spec_mask;
    logic nested;
    logic master;
    logic auto_eoi;
    logic rot_aeoi;
  } pra_mode_t;
endpackage

// File: rtl/pra_req_capture.sv
module pra_req_capture #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic [N_IN-1:0] req_i,
  input  logic [N_IN-1:0] trig_i,
  input  logic [N_IN-1:0] ack_clr_i,
  output logic [N_IN-1:0] irr_o
);
  import pra_pkg::*;

  logic [N_IN-1:0] prev_q, prev_d;
  logic [N_IN-1:0] irr_q, irr_d;
  logic [N_IN-1:0] rise;

  assign rise = req_i & ~prev_q;

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    always_comb begin
      if (init_i) begin
        irr_d[g] = 1'b0;
      end else if (trig_i[g] == TRIG_LEVEL) begin
        irr_d[g] = req_i[g];
      end else begin
        irr_d[g] = (irr_q[g] & ~ack_clr_i[g]) | rise[g];
      end
    end
  end

  always_comb begin
    prev_d = init_i ? '0 : req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_d;
      prev_q <= prev_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pra_prio_find.sv
module pra_prio_find #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN),
  localparam int PW   = IDX_W + 1
) (
  input  logic [N_IN-1:0]  vec_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [PW-1:0]    rank_o
);
  logic [N_IN-1:0] rot;

  always_comb begin
    for (int k = 0; k < N_IN; k++) begin
      rot[k] = vec_i[IDX_W'(k) + base_i];
    end
  end

  always_comb begin
    rank_o = PW'(N_IN);
    for (int k = N_IN - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = PW'(k);
    end
  end
endmodule

// File: rtl/pra_service.sv
module pra_service #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             ack_fire_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             auto_eoi_i,
  input  logic             rot_aeoi_i,
  input  logic             prio_ld_i,
  input  logic [IDX_W-1:0] prio_base_i,
  input  logic [N_IN-1:0]  isr_clr_i,
  output logic [N_IN-1:0]  isr_o,
  output logic [IDX_W-1:0] base_o
);
  logic [N_IN-1:0]  isr_q, isr_d, set_v;
  logic [IDX_W-1:0] base_q, base_d;

  always_comb begin
    set_v = '0;
    if (ack_fire_i && !auto_eoi_i) set_v[win_i] = 1'b1;
    if (init_i) isr_d = '0;
    else        isr_d = (isr_q & ~isr_clr_i) | set_v;
  end

  always_comb begin
    base_d = base_q;
    if (init_i)                                       base_d = '0;
    else if (prio_ld_i)                               base_d = prio_base_i;
    else if (ack_fire_i && auto_eoi_i && rot_aeoi_i)  base_d = win_i + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int N_IN     = 8,
  parameter int CASC_IDX = 2,
  localparam int IDX_W   = $clog2(N_IN),
  localparam int PW      = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [N_IN-1:0]  req_i,
  input  logic             trig_wr_i,
  input  logic [N_IN-1:0]  trig_i,
  input  logic             mask_wr_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic             spec_mask_i,
  input  logic             nested_i,
  input  logic             master_i,
  input  logic             auto_eoi_i,
  input  logic             rot_aeoi_i,
  input  logic             prio_ld_i,
  input  logic [IDX_W-1:0] prio_base_i,
  input  logic [N_IN-1:0]  isr_clr_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic [IDX_W-1:0] win_idx_o
);
  import pra_pkg::*;

  pra_mode_t mode;
  assign mode = '{spec_mask: spec_mask_i, nested: nested_i, master: master_i,
                  auto_eoi: auto_eoi_i, rot_aeoi: rot_aeoi_i};

  logic [N_IN-1:0]  trig_q, trig_d;
  logic [N_IN-1:0]  imr_q, imr_d;
  logic [N_IN-1:0]  irr_q, isr_q;
  logic [IDX_W-1:0] base_q;
  logic [N_IN-1:0]  pend_v, cur_v, ack_clr;
  logic [PW-1:0]    pend_rank, cur_rank;
  logic             ack_fire;

  always_comb begin
    trig_d = trig_wr_i ? trig_i : trig_q;
    imr_d  = imr_q;
    if (init_i)         imr_d = '0;
    else if (mask_wr_i) imr_d = mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      imr_q  <= '0;
    end else begin
      trig_q <= trig_d;
      imr_q  <= imr_d;
    end
  end

  assign pend_v = irr_q & ~imr_q;

  always_comb begin
    cur_v = isr_q;
    if (mode.spec_mask) cur_v = cur_v & ~imr_q;
    if (mode.nested && mode.master) cur_v[CASC_IDX] = 1'b0;
  end

  pra_prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pend_find (
    .vec_i(pend_v), .base_i(base_q), .rank_o(pend_rank));

  pra_prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_cur_find (
    .vec_i(cur_v), .base_i(base_q), .rank_o(cur_rank));

  assign int_o     = (pend_rank < cur_rank);
  assign win_idx_o = pend_rank[IDX_W-1:0] + base_q;
  assign ack_fire  = ack_i & int_o;

  always_comb begin
    ack_clr = '0;
    if (ack_fire) ack_clr[win_idx_o] = ~trig_q[win_idx_o];
  end

  pra_req_capture #(.N_IN(N_IN)) u_capture (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .req_i(req_i),
    .trig_i(trig_q), .ack_clr_i(ack_clr), .irr_o(irr_q));

  pra_service #(.N_IN(N_IN), .IDX_W(IDX_W)) u_service (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .ack_fire_i(ack_fire),
    .win_i(win_idx_o), .auto_eoi_i(mode.auto_eoi), .rot_aeoi_i(mode.rot_aeoi),
    .prio_ld_i(prio_ld_i), .prio_base_i(prio_base_i), .isr_clr_i(isr_clr_i),
    .isr_o(isr_q), .base_o(base_q));
endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_i,
  input logic [N_IN-1:0]  req_i,
  input logic             ack_i,
  input logic             auto_eoi_i,
  input logic             rot_aeoi_i,
  input logic             prio_ld_i,
  input logic [N_IN-1:0]  isr_clr_i,
  input logic             int_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [N_IN-1:0]  irr_q,
  input logic [N_IN-1:0]  imr_q,
  input logic [N_IN-1:0]  isr_q,
  input logic [N_IN-1:0]  trig_q,
  input logic [IDX_W-1:0] base_q
);
  a_r4_winner_pending_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (irr_q[win_idx_o] && !imr_q[win_idx_o]));

  a_r3_level_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> (((irr_q ^ $past(req_i)) & $past(trig_q)) == '0));

  a_r9_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !auto_eoi_i && !init_i && !isr_clr_i[win_idx_o])
    |=> isr_q[$past(win_idx_o)]);

  a_r9_ack_drops_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !trig_q[win_idx_o] && !req_i[win_idx_o] && !init_i)
    |=> !irr_q[$past(win_idx_o)]);

  a_r10_aeoi_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && auto_eoi_i && rot_aeoi_i && !init_i && !prio_ld_i)
    |=> (base_q == IDX_W'($past(win_idx_o) + 1'b1)));

  a_r10_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi_i && !init_i && isr_clr_i == '0) |=> $stable(isr_q));

  a_r11_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (isr_q == '0 && base_q == '0 && imr_q == '0 && !int_o));
endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .req_i(req_i), .ack_i(ack_i),
  .auto_eoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i), .prio_ld_i(prio_ld_i),
  .isr_clr_i(isr_clr_i), .int_o(int_o), .win_idx_o(win_idx_o), .irr_q(irr_q),
  .imr_q(imr_q), .isr_q(isr_q), .trig_q(trig_q), .base_q(base_q));

// File: tb/test_prio_irq_arbiter.sv
module test_prio_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_i, trig_wr_i, mask_wr_i, spec_mask_i, nested_i, master_i;
  logic       auto_eoi_i, rot_aeoi_i, prio_ld_i, ack_i;
  logic [7:0] req_i, trig_i, mask_i, isr_clr_i;
  logic [2:0] prio_base_i;
  logic       int_o;
  logic [2:0] win_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  prio_irq_arbiter i_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .req_i(req_i),
    .trig_wr_i(trig_wr_i), .trig_i(trig_i), .mask_wr_i(mask_wr_i), .mask_i(mask_i),
    .spec_mask_i(spec_mask_i), .nested_i(nested_i), .master_i(master_i),
    .auto_eoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i), .prio_ld_i(prio_ld_i),
    .prio_base_i(prio_base_i), .isr_clr_i(isr_clr_i), .ack_i(ack_i),
    .int_o(int_o), .win_idx_o(win_idx_o));

  typedef struct packed {
    logic [2:0] base;
    logic [7:0] pat;
    logic       exp_int;
    logic [2:0] exp_win;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 8'h81, 1'b1, 3'd0},
    '{3'd1, 8'h81, 1'b1, 3'd7},
    '{3'd3, 8'h0C, 1'b1, 3'd3},
    '{3'd4, 8'h0C, 1'b1, 3'd2},
    '{3'd7, 8'hFF, 1'b1, 3'd7},
    '{3'd5, 8'h10, 1'b1, 3'd4},
    '{3'd0, 8'h00, 1'b0, 3'd0},
    '{3'd2, 8'h03, 1'b1, 3'd0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic check(string tag, logic exp_int, logic [2:0] exp_win);
    n_chk++;
    if (int_o !== exp_int || (exp_int && win_idx_o !== exp_win)) begin
      n_bad++;
      $display("FAIL %s: int=%b win=%0d expected int=%b win=%0d",
               tag, int_o, win_idx_o, exp_int, exp_win);
    end
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic clr_isr(logic [7:0] v);
    isr_clr_i = v; step(); isr_clr_i = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; init_i = 0; trig_wr_i = 0; mask_wr_i = 0; spec_mask_i = 0;
    nested_i = 0; master_i = 0; auto_eoi_i = 0; rot_aeoi_i = 0; prio_ld_i = 0;
    ack_i = 0; req_i = '0; trig_i = '0; mask_i = '0; isr_clr_i = '0; prio_base_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, 3'd0);
    rst_n = 1'b1;
    step();

    // R5 R13: priority table, all lines in level mode
    trig_wr_i = 1; trig_i = 8'hFF; step(); trig_wr_i = 0;
    for (int i = 0; i < 8; i++) begin
      prio_ld_i = 1; prio_base_i = VECS[i].base; req_i = VECS[i].pat;
      step();
      prio_ld_i = 0;
      check("R5 rotating priority", VECS[i].exp_int, VECS[i].exp_win);
    end
    req_i = '0; step();
    trig_wr_i = 1; trig_i = '0; prio_ld_i = 1; prio_base_i = 3'd0; step();
    trig_wr_i = 0; prio_ld_i = 0;

    // R4 mask
    mask_wr_i = 1; mask_i = 8'h02; req_i = 8'h02; step(); mask_wr_i = 0;
    check("R4 masked request", 1'b0, 3'd0);
    mask_wr_i = 1; mask_i = 8'h00; step(); mask_wr_i = 0;
    check("R4 unmasked request", 1'b1, 3'd1);
    req_i = 8'h00; step();
    check("R2 falling edge keeps pending", 1'b1, 3'd1);
    pulse_ack();
    check("R9 ack sets in-service and drops edge", 1'b0, 3'd0);
    req_i = 8'h02; step();
    check("R6 equal rank blocked", 1'b0, 3'd0);
    req_i = 8'h03; step();
    check("R6 better rank nests", 1'b1, 3'd0);
    clr_isr(8'h02);
    check("R12 in-service clear", 1'b1, 3'd0);
    pulse_ack();
    check("R6 lower pending blocked by in-service", 1'b0, 3'd0);
    clr_isr(8'h01);
    check("R12 clear reveals next", 1'b1, 3'd1);
    pulse_ack();
    clr_isr(8'hFF);
    check("R2 held line not recaptured", 1'b0, 3'd0);

    // R7 special mask
    req_i = 8'h00; step();
    req_i = 8'h01; step();
    req_i = 8'h00; ack_i = 1; step(); ack_i = 0;
    req_i = 8'h08; step(); req_i = 8'h00; step();
    check("R6 blocked by in-service 0", 1'b0, 3'd0);
    mask_wr_i = 1; mask_i = 8'h01; spec_mask_i = 1; step(); mask_wr_i = 0;
    check("R7 special mask ignores masked in-service", 1'b1, 3'd3);
    spec_mask_i = 0; step();
    check("R7 normal mask counts in-service", 1'b0, 3'd0);
    init_i = 1; step(); init_i = 0;

    // R8 special fully nested
    req_i = 8'h04; step();
    req_i = 8'h00; ack_i = 1; step(); ack_i = 0;
    req_i = 8'h20; step(); req_i = 8'h00; step();
    check("R8 cascade in-service counted", 1'b0, 3'd0);
    master_i = 1; nested_i = 1; step();
    check("R8 nested master ignores cascade", 1'b1, 3'd5);
    master_i = 0; step();
    check("R8 nested non-master counts cascade", 1'b0, 3'd0);
    nested_i = 0; init_i = 1; step(); init_i = 0;

    // R3 level mode
    trig_wr_i = 1; trig_i = 8'h10; step(); trig_wr_i = 0;
    req_i = 8'h10; step();
    check("R3 level request", 1'b1, 3'd4);
    pulse_ack();
    check("R9 level ack in service", 1'b0, 3'd0);
    clr_isr(8'h10);
    check("R3 ack keeps level pending", 1'b1, 3'd4);
    req_i = 8'h00; step();
    check("R3 level follows line low", 1'b0, 3'd0);

    // R10 automatic end of interrupt
    auto_eoi_i = 1; rot_aeoi_i = 1;
    req_i = 8'h40; step(); req_i = 8'h00; step();
    check("R10 edge request 6", 1'b1, 3'd6);
    pulse_ack();
    rot_aeoi_i = 0;
    req_i = 8'h81; step(); req_i = 8'h00; step();
    check("R10 base rotated past winner", 1'b1, 3'd7);
    pulse_ack();
    check("R10 no in-service set, base kept", 1'b1, 3'd0);
    pulse_ack();
    check("R10 all consumed", 1'b0, 3'd0);
    auto_eoi_i = 0;

    // R11 init keeps trigger modes, clears base
    req_i = 8'h10; step();
    init_i = 1; step(); init_i = 0;
    check("R11 init clears pending", 1'b0, 3'd0);
    step();
    check("R11 level line recaptured", 1'b1, 3'd4);
    req_i = 8'h00; step();
    check("R11 trigger mode kept by init", 1'b0, 3'd0);
    req_i = 8'h81; step(); req_i = 8'h00; step();
    check("R11 base cleared by init", 1'b1, 3'd0);

    // R1 full reset clears trigger modes
    rst_n = 1'b0; @(negedge clk);
    check("R1 reset drops int", 1'b0, 3'd0);
    @(negedge clk); rst_n = 1'b1; step();
    req_i = 8'h10; step(); req_i = 8'h00; step();
    check("R1 reset returns line to edge mode", 1'b1, 3'd4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule